// File: doc/BRIEF.md
# Low-Power Mode Control Unit

This unit owns the power-control register of a small 8-bit microcontroller and the mode sequencing around it. Three register bits matter: an enable for the power-fail interrupt, a stop request and an idle request. From these the unit produces the clock enables for the CPU, the peripherals, the watchdog and the oscillator. It also drives the strobe and port-mode overrides that the pads take while the part sleeps.

Idle stops only the CPU. Any pending interrupt or any reset wakes it. Stop shuts the oscillator down. Software can request stop only through a write that carries the timed-access unlock qualifier, and only a reset event ends it. After every reset the unit counts a start-up delay before it gives any clock enable back to the core, so that the oscillator can settle.

Top module: `pwr_mode_ctl`

## Requirements
- R1: Every reset (asynchronous `rst_n` low, or `por_i` or `ext_rst_i` high at a clock edge) clears all three control bits. `rd_data_o` returns the power-fail enable in bit 3, stop in bit 1 and idle in bit 0. All other bits read 0.
- R2: A write (`wr_en_i` high) loads the power-fail enable from `wr_data_i[3]` and the idle bit from `wr_data_i[0]`, whatever the state of `unlock_i`. `pfail_irq_en_o` follows the power-fail enable bit.
- R3: The stop bit takes `wr_data_i[1]` only when `unlock_i` is high in the same cycle as the write. A write without the unlock leaves the stop bit unchanged.
- R4: While idle is set, `cpu_clk_en_o` is low and `io_clk_en_o` stays high. When `irq_pend_i` is high at a clock edge, the idle bit is cleared.
- R5: While stop is set, `cpu_clk_en_o`, `io_clk_en_o`, `wdt_en_o` and `osc_en_o` are all low.
- R6: While stop is set, writes and interrupts change no register bit. Only a reset event ends stop mode.
- R7: After each reset event, `startup_done_o` stays low for exactly 21504 clock edges and then rises. Until it rises, the CPU, peripheral and watchdog enables stay low. A new reset event restarts the count.
- R8: In idle or stop, `lp_pin_ovr_o` and `ale_o` are high. `psen_o` is high in idle and low in stop. Outside low-power modes, all three are low.
- R9: With `mem_expanded_i` high, `p0_hiz_o` is high in both idle and stop, and `p2_addr_o` is high only in idle. With `mem_expanded_i` low, both are low.
- R10: An unlocked write with both bit 1 and bit 0 set enters stop and leaves idle clear. Setting stop always clears idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on reset event, synchronous, active high |
| ext_rst_i | input | 1 | External reset pin, synchronous, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| unlock_i | input | 1 | Timed-access unlock qualifier for the write |
| irq_pend_i | input | 1 | Any interrupt pending |
| mem_expanded_i | input | 1 | 1 = expanded external memory bus, 0 = byte-wide |
| rd_data_o | output | 8 | Register read value |
| pfail_irq_en_o | output | 1 | Power-fail interrupt enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| io_clk_en_o | output | 1 | Peripheral clock enable |
| wdt_en_o | output | 1 | Watchdog enable |
| osc_en_o | output | 1 | Oscillator enable |
| startup_done_o | output | 1 | Start-up delay complete |
| lp_pin_ovr_o | output | 1 | Pads take the low-power values below |
| ale_o | output | 1 | Address latch strobe value in low power |
| psen_o | output | 1 | Program store strobe value in low power |
| p0_hiz_o | output | 1 | Port 0 high impedance |
| p2_addr_o | output | 1 | Port 2 drives address instead of latch data |

## Verification
The bench goes after the stop bit's protection: a design that let a plain write set or clear stop, or let an interrupt or a plain write end it, would leave the register and clock enables out of step with the model. It also counts the start-up delay edge by edge after each kind of reset, so a count that is one cycle off, or one that is not restarted, shows up at the 21504 boundary. A write that sets both mode bits catches a design that enters idle and stop together. Cycles where an interrupt arrives together with an idle write show whether the wake-up takes priority.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_PFIE = 3;
  localparam int BIT_STOP = 1;
  localparam int BIT_IDLE = 0;

  typedef struct packed {
    logic pfie;
    logic stop;
    logic idle;
  } pmc_ctrl_t;
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_evt,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             unlock,
  input  logic             irq,
  output pmc_ctrl_t        ctrl_q
);
  pmc_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (rst_evt) begin
      ctrl_d = '0;
    end else if (!ctrl_q.stop) begin
      if (wr_en) begin
        ctrl_d.pfie = wr_data[BIT_PFIE];
        ctrl_d.idle = wr_data[BIT_IDLE];
        if (unlock) ctrl_d.stop = wr_data[BIT_STOP];
        if (ctrl_d.stop) ctrl_d.idle = 1'b0;
      end
      if (irq) ctrl_d.idle = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (ctrl_q == '0));
  p_stop_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.stop) |-> $past(wr_en && unlock && wr_data[BIT_STOP]));
  p_idle_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.idle && irq && !rst_evt) |=> !ctrl_q.idle);
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.stop && !rst_evt) |=> (ctrl_q == $past(ctrl_q)));
  p_one_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q.stop && ctrl_q.idle));
endmodule

// File: rtl/pmc_startup_cnt.sv
module pmc_startup_cnt #(
  parameter int STARTUP_CYCLES = 21504,
  localparam int CNT_W = $clog2(STARTUP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_evt,
  output logic done
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STARTUP_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q == LIMIT);
  assign cnt_en = rst_evt || !done;

  always_comb begin
    if (rst_evt) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  p_cnt_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (cnt_q == '0));
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_evt && !done) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/pmc_pin_ctl.sv
module pmc_pin_ctl (
  input  logic idle,
  input  logic stop,
  input  logic mem_expanded,
  output logic pin_ovr,
  output logic ale,
  output logic psen,
  output logic p0_hiz,
  output logic p2_addr
);
  logic low_pwr;

  always_comb begin
    low_pwr = idle || stop;
    pin_ovr = low_pwr;
    ale     = low_pwr;
    psen    = idle && !stop;
    p0_hiz  = low_pwr && mem_expanded;
    p2_addr = idle && !stop && mem_expanded;
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pmc_pkg::*;
#(
  parameter int STARTUP_CYCLES = 21504
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_i,
  input  logic             ext_rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             unlock_i,
  input  logic             irq_pend_i,
  input  logic             mem_expanded_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             pfail_irq_en_o,
  output logic             cpu_clk_en_o,
  output logic             io_clk_en_o,
  output logic             wdt_en_o,
  output logic             osc_en_o,
  output logic             startup_done_o,
  output logic             lp_pin_ovr_o,
  output logic             ale_o,
  output logic             psen_o,
  output logic             p0_hiz_o,
  output logic             p2_addr_o
);
  pmc_ctrl_t ctrl;
  logic      rst_evt;
  logic      done;

  assign rst_evt = por_i || ext_rst_i;

  pmc_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_evt (rst_evt),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .unlock  (unlock_i),
    .irq     (irq_pend_i),
    .ctrl_q  (ctrl)
  );

  pmc_startup_cnt #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_evt (rst_evt),
    .done    (done)
  );

  pmc_pin_ctl u_pin (
    .idle         (ctrl.idle),
    .stop         (ctrl.stop),
    .mem_expanded (mem_expanded_i),
    .pin_ovr      (lp_pin_ovr_o),
    .ale          (ale_o),
    .psen         (psen_o),
    .p0_hiz       (p0_hiz_o),
    .p2_addr      (p2_addr_o)
  );

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[BIT_PFIE] = ctrl.pfie;
    rd_data_o[BIT_STOP] = ctrl.stop;
    rd_data_o[BIT_IDLE] = ctrl.idle;
    pfail_irq_en_o      = ctrl.pfie;
    osc_en_o            = !ctrl.stop;
    io_clk_en_o         = done && !ctrl.stop;
    wdt_en_o            = done && !ctrl.stop;
    cpu_clk_en_o        = done && !ctrl.stop && !ctrl.idle;
    startup_done_o      = done;
  end

  p_stop_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[BIT_STOP] |-> !(cpu_clk_en_o || io_clk_en_o || wdt_en_o || osc_en_o));
  p_idle_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[BIT_IDLE] |-> !cpu_clk_en_o);
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_done_o |-> !(cpu_clk_en_o || io_clk_en_o || wdt_en_o));
  p_strobe_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[BIT_STOP] |-> (ale_o && !psen_o && lp_pin_ovr_o));
  p_p0_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_expanded_i && (rd_data_o[BIT_STOP] || rd_data_o[BIT_IDLE])) |-> p0_hiz_o);
endmodule

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;
  localparam int DLY = 21504;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_i = 1'b0, ext_rst_i = 1'b0, wr_en_i = 1'b0, unlock_i = 1'b0;
  logic irq_pend_i = 1'b0, mem_expanded_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic pfail_irq_en_o, cpu_clk_en_o, io_clk_en_o, wdt_en_o, osc_en_o;
  logic startup_done_o, lp_pin_ovr_o, ale_o, psen_o, p0_hiz_o, p2_addr_o;

  int n_cmp = 0, n_bad = 0;
  logic m_pf, m_st, m_id;
  int   m_cnt;

  always #2.5 clk = ~clk;

  pwr_mode_ctl u0 (.*);

  function automatic logic [7:0] exp_rd(logic pf, logic st, logic id);
    return {4'b0, pf, 1'b0, st, id};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n || por_i || ext_rst_i) begin
      m_pf = 0; m_st = 0; m_id = 0; m_cnt = 0;
    end else begin
      if (m_cnt < DLY) m_cnt++;
      if (!m_st) begin
        if (wr_en_i) begin
          m_pf = wr_data_i[3];
          m_id = wr_data_i[0];
          if (unlock_i) m_st = wr_data_i[1];
          if (m_st) m_id = 0;
        end
        if (irq_pend_i) m_id = 0;
      end
    end
  endtask

  task automatic compare();
    logic dn;
    dn = (m_cnt == DLY);
    chk("R1/R2/R3 rd_data", rd_data_o, exp_rd(m_pf, m_st, m_id));
    chk("R2 pfail_en", pfail_irq_en_o, m_pf);
    chk("R4/R5 cpu_en", cpu_clk_en_o, dn && !m_st && !m_id);
    chk("R4/R5 io_en", io_clk_en_o, dn && !m_st);
    chk("R5 wdt_en", wdt_en_o, dn && !m_st);
    chk("R5 osc_en", osc_en_o, !m_st);
    chk("R7 done", startup_done_o, dn);
    chk("R8 ovr", lp_pin_ovr_o, m_st || m_id);
    chk("R8 ale", ale_o, m_st || m_id);
    chk("R8 psen", psen_o, m_id);
    chk("R9 p0", p0_hiz_o, mem_expanded_i && (m_st || m_id));
    chk("R9 p2", p2_addr_o, mem_expanded_i && m_id);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_in();
    wr_en_i = 0; unlock_i = 0; irq_pend_i = 0; por_i = 0; ext_rst_i = 0;
  endtask

  task automatic wr(logic [7:0] d, logic ul);
    wr_en_i = 1; wr_data_i = d; unlock_i = ul; cyc(); idle_in();
  endtask

  task automatic measure_delay(string tag);
    int n = 0;
    while (!startup_done_o && n < DLY + 10) begin cyc(); n++; end
    chk(tag, n, DLY);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    m_pf = 0; m_st = 0; m_id = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    compare();
    chk("R1 reset rd", rd_data_o, 8'h00);
    rst_n = 1;
    measure_delay("R7 delay after rst_n");

    // R2: free writes of pfie and idle, bit 2 reads 0
    wr(8'h0D, 0);
    chk("R2 pf+idle set", rd_data_o, 8'h09);
    chk("R4 io runs in idle", io_clk_en_o, 1'b1);
    // R4: interrupt wakes, even against a simultaneous idle write
    irq_pend_i = 1; wr_en_i = 1; wr_data_i = 8'h01; cyc(); idle_in();
    chk("R4 irq clears idle", rd_data_o[0], 1'b0);
    // R3: locked stop write ignored
    wr(8'h02, 0);
    chk("R3 locked stop ignored", rd_data_o[1], 1'b0);
    // R10: both bits with unlock
    mem_expanded_i = 1;
    wr(8'h03, 1);
    chk("R10 stop wins", rd_data_o, 8'h02);
    chk("R8 psen low stop", psen_o, 1'b0);
    chk("R9 p0 hiz stop", p0_hiz_o, 1'b1);
    // R6: writes/interrupts ignored in stop
    wr(8'h00, 1);
    irq_pend_i = 1; cyc(); idle_in();
    chk("R6 stop sticky", rd_data_o, 8'h02);
    ext_rst_i = 1; cyc(); idle_in();
    chk("R6 ext reset ends stop", rd_data_o, 8'h00);
    measure_delay("R7 delay after ext reset");

    // random phase, no unlock
    for (int i = 0; i < 1500; i++) begin
      wr_en_i = ($urandom % 3) == 0;
      wr_data_i = 8'($urandom);
      irq_pend_i = ($urandom % 5) == 0;
      mem_expanded_i = $urandom % 2;
      unlock_i = 0;
      cyc();
    end
    idle_in();
    // random phase with unlock until stop entered
    for (int i = 0; i < 400; i++) begin
      wr_en_i = ($urandom % 2) == 0;
      wr_data_i = 8'($urandom);
      irq_pend_i = ($urandom % 4) == 0;
      unlock_i = ($urandom % 8) == 0;
      mem_expanded_i = $urandom % 2;
      cyc();
    end
    idle_in();
    // R7: restart count mid-delay by power-on reset
    por_i = 1; cyc(); idle_in();
    chk("R1 por clears", rd_data_o, 8'h00);
    repeat (100) cyc();
    por_i = 1; cyc(); idle_in();
    measure_delay("R7 delay restart after por");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule